// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage with Banked Feedback Memory

This block is one stage of a radix-2 decimation-in-frequency FFT pipeline built on the single-path delay-feedback scheme. It takes one complex sample per valid cycle and produces one complex result per valid cycle. The stage works on groups of 2·DEPTH valid samples. During the first DEPTH samples of a group (the fill phase) each input is parked in the feedback storage, and the word previously held at that position is sent out. During the second DEPTH samples (the butterfly phase) the parked sample and the new input are combined. Their sum goes back into storage and leaves during the next fill phase. Their difference is rotated by a twiddle factor and sent out at once.

The feedback storage is not a flip-flop shift line. It is two single-port banks of DEPTH/2 words each: even positions sit in one bank and odd positions in the other. A rotating one-hot ring selects the word, so no binary address decoder is needed and only one word is written in a given cycle. Registers on both sides of the processing element keep the memory access off the critical path. Twiddle factors come from a small table that is computed when the design is elaborated and indexed by the same ring.

Top module: `sdf_mem_stage`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after a cycle with `in_valid` high, and one result appears for each accepted sample. In a cycle where no result is produced, `out_re` and `out_im` hold their previous value. Cycles with `in_valid` low do not advance the stage position or phase.
- R2: Accepted samples are counted from reset in groups of 2·DEPTH. The first DEPTH samples of each group form the fill phase. At fill position p the input is stored, and the output is the word held at p, sign-extended to DATA_W+2 bits.
- R3: At butterfly position p the word s held at p is combined with the input x. The output is (s − x)·W^p with re = floor((dr·wr − di·wi) / 2^(TW_W−2)) and im = floor((dr·wi + di·wr) / 2^(TW_W−2)), and s + x replaces the word at p.
- R4: Stored sums keep full DATA_W+1 bit precision and return unchanged in the next fill phase, including the extreme sums −2^DATA_W and 2^DATA_W−2.
- R5: The twiddle for position p is wr = round(cos(2πp/(2·DEPTH))·2^(TW_W−2)) and wi = round(−sin(2πp/(2·DEPTH))·2^(TW_W−2)), with halves rounded away from zero.
- R6: Synchronous active-low reset clears `out_valid` and both output words, returns the stage to position 0 of the fill phase, and zeroes the storage, so the first DEPTH results after reset are zero.
- R7: The storage is two single-port banks: even positions in one bank and odd positions in the other. Word selection comes from a one-hot ring. In each cycle at most one bank is accessed, and that bank reads its word before it writes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | DATA_W | Real part of input, two's complement |
| in_im | input | DATA_W | Imaginary part of input, two's complement |
| out_valid | output | 1 | Result present |
| out_re | output | DATA_W+2 | Real part of result |
| out_im | output | DATA_W+2 | Imaginary part of result |

## Verification
Every result leaves the stage exactly two clock cycles after its sample is accepted: one cycle for the input register and one for the output register. The bench keeps a two-deep record of `in_valid` and compares `out_valid` with it at every falling edge. The stored sum that a butterfly creates reappears DEPTH accepted samples later, not DEPTH cycles later, so the reference model counts accepted samples and not clock edges. Expected results go into a queue in acceptance order, and each result is compared in the cycle the two-register path predicts, including runs with idle gaps and a reset in the middle of a run. Two instances, with DEPTH 8 and DEPTH 4, are driven with the same stimulus.

// File: rtl/sdf_pkg.sv
// Shared definitions for the delay-feedback FFT stage.
// Assumes constant real math is available during elaboration.
package sdf_pkg;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_BFLY = 1'b1
    } sdf_phase_e;

    localparam real TWO_PI = 6.283185307179586;

    // Fixed-point twiddle component, rounded half away from zero.
    function automatic int tw_fixed(input int k, input int n, input int frac, input bit imag_part);
        real ang;
        real v;
        real s;
        ang = TWO_PI * real'(k) / real'(n);
        v   = imag_part ? -$sin(ang) : $cos(ang);
        s   = v * (2.0 ** frac);
        return (s < 0.0) ? $rtoi(s - 0.5) : $rtoi(s + 0.5);
    endfunction

endpackage

// File: rtl/sdf_ring_ctrl.sv
// One-hot position ring plus phase flag for the delay-feedback stage.
// Advances once per accepted sample. The phase flips when the ring wraps.
// Assumes DEPTH >= 2.
module sdf_ring_ctrl #(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [DEPTH-1:0]    ring,
    output sdf_pkg::sdf_phase_e phase
);
    import sdf_pkg::*;

    // Rotate the ring on each accepted sample; toggle the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring  <= DEPTH'(1);
            phase <= PH_FILL;
        end else if (adv) begin
            ring <= {ring[DEPTH-2:0], ring[DEPTH-1]};
            if (ring[DEPTH-1]) begin
                phase <= (phase == PH_FILL) ? PH_BFLY : PH_FILL;
            end
        end
    end

    // R7: exactly one word position is selected at any time.
    assert_ring_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);

    // R1: idle cycles leave the position unchanged.
    assert_ring_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ring));

    // R2: the phase changes only when the ring wraps.
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && ring[DEPTH-1]) |=> $stable(phase));

endmodule

// File: rtl/sdf_bank.sv
// Single-port storage bank with a one-hot word select.
// A selected word is read combinationally and rewritten at the clock edge,
// so each access reads the old value before the write lands.
// Assumes sel carries at most one set bit; all-zero sel means the bank is idle.
module sdf_bank #(
    parameter int WORDS = 4,
    parameter int WIDTH = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WORDS-1:0] sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Each word is written only when its select line is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (wr_en && sel[w]) begin
                word_q[w] <= wdata;
            end
        end
    end

    // AND-OR read mux driven by the one-hot select.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (sel[i]) begin
                rdata = rdata | word_q[i];
            end
        end
    end

    // R7: the word select of a single-port bank is one-hot or idle.
    assert_bank_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) <= 1);

endmodule

// File: rtl/sdf_pe.sv
// Radix-2 butterfly plus twiddle rotation for one delay-feedback stage.
// Fill phase: the stored word passes out unrotated and the input is written back.
// Butterfly phase: the difference is rotated by W^p and the sum is written back.
// The twiddle table is built at elaboration and indexed by the one-hot ring.
module sdf_pe #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 12,
    parameter int TW_W   = 16
) (
    input  sdf_pkg::sdf_phase_e phase,
    input  logic [DEPTH-1:0]    ring,
    input  logic signed [DATA_W-1:0] x_re,
    input  logic signed [DATA_W-1:0] x_im,
    input  logic signed [DATA_W:0]   st_re,
    input  logic signed [DATA_W:0]   st_im,
    output logic signed [DATA_W:0]   wb_re,
    output logic signed [DATA_W:0]   wb_im,
    output logic signed [DATA_W+1:0] y_re,
    output logic signed [DATA_W+1:0] y_im
);
    import sdf_pkg::*;

    localparam int MW   = DATA_W + 1;
    localparam int OW   = DATA_W + 2;
    localparam int FRAC = TW_W - 2;
    localparam int PW   = MW + TW_W;

    logic [TW_W-1:0] tab_re [DEPTH];
    logic [TW_W-1:0] tab_im [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tw
        localparam int CRE = tw_fixed(k, 2 * DEPTH, FRAC, 1'b0);
        localparam int CIM = tw_fixed(k, 2 * DEPTH, FRAC, 1'b1);
        assign tab_re[k] = TW_W'(CRE);
        assign tab_im[k] = TW_W'(CIM);
    end

    logic signed [TW_W-1:0] w_re;
    logic signed [TW_W-1:0] w_im;

    // Twiddle lookup by the one-hot ring (AND-OR, no decoder).
    always_comb begin
        w_re = '0;
        w_im = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ring[k]) begin
                w_re = w_re | tab_re[k];
                w_im = w_im | tab_im[k];
            end
        end
    end

    logic signed [MW-1:0] xe_re, xe_im, sum_re, sum_im, dif_re, dif_im;
    assign xe_re  = {x_re[DATA_W-1], x_re};
    assign xe_im  = {x_im[DATA_W-1], x_im};
    assign sum_re = st_re + xe_re;
    assign sum_im = st_im + xe_im;
    assign dif_re = st_re - xe_re;
    assign dif_im = st_im - xe_im;

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    assign p_rr = dif_re * w_re;
    assign p_ii = dif_im * w_im;
    assign p_ri = dif_re * w_im;
    assign p_ir = dif_im * w_re;

    logic signed [PW:0] rot_re, rot_im;
    assign rot_re = {p_rr[PW-1], p_rr} - {p_ii[PW-1], p_ii};
    assign rot_im = {p_ri[PW-1], p_ri} + {p_ir[PW-1], p_ir};

    logic unused_pe;
    assign unused_pe = ^{rot_re[FRAC-1:0], rot_re[PW:FRAC+OW],
                         rot_im[FRAC-1:0], rot_im[PW:FRAC+OW]};

    // Select the output and write-back word for the current phase.
    always_comb begin
        if (phase == PH_FILL) begin
            wb_re = xe_re;
            wb_im = xe_im;
            y_re  = {st_re[MW-1], st_re};
            y_im  = {st_im[MW-1], st_im};
        end else begin
            wb_re = sum_re;
            wb_im = sum_im;
            y_re  = rot_re[FRAC +: OW];
            y_im  = rot_im[FRAC +: OW];
        end
    end

endmodule

// File: rtl/sdf_mem_stage.sv
// One radix-2 delay-feedback FFT stage with DEPTH words of feedback storage,
// held in two single-port banks (even and odd positions) and addressed by a
// one-hot ring. One register sits in front of the processing element and one
// after it. Latency is two cycles from an accepted sample to its result.
// Assumes DEPTH is even and at least 2.
module sdf_mem_stage #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 12,
    parameter int TW_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    output logic signed [DATA_W+1:0] out_re,
    output logic signed [DATA_W+1:0] out_im
);
    import sdf_pkg::*;

    localparam int HALF = DEPTH / 2;
    localparam int MW   = DATA_W + 1;
    localparam int OW   = DATA_W + 2;
    localparam int BW   = 2 * MW;

    logic                     vld_q;
    logic signed [DATA_W-1:0] xq_re, xq_im;

    // Input register in front of the processing element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            xq_re <= '0;
            xq_im <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                xq_re <= in_re;
                xq_im <= in_im;
            end
        end
    end

    logic [DEPTH-1:0] ring;
    sdf_phase_e       phase;

    sdf_ring_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (vld_q),
        .ring  (ring),
        .phase (phase)
    );

    logic [HALF-1:0] bsel [2];
    logic [BW-1:0]   brd  [2];
    logic [BW-1:0]   wdata;
    logic signed [MW-1:0] wb_re, wb_im;

    assign wdata = {wb_re, wb_im};

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar i = 0; i < HALF; i++) begin : g_sel
            assign bsel[b][i] = ring[2 * i + b] & vld_q;
        end
        sdf_bank #(.WORDS(HALF), .WIDTH(BW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (bsel[b]),
            .wr_en (vld_q),
            .wdata (wdata),
            .rdata (brd[b])
        );
    end

    logic [BW-1:0] st_word;
    assign st_word = brd[0] | brd[1];

    logic signed [OW-1:0] y_re, y_im;

    sdf_pe #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TW_W(TW_W)) u_pe (
        .phase (phase),
        .ring  (ring),
        .x_re  (xq_re),
        .x_im  (xq_im),
        .st_re (st_word[BW-1:MW]),
        .st_im (st_word[MW-1:0]),
        .wb_re (wb_re),
        .wb_im (wb_im),
        .y_re  (y_re),
        .y_im  (y_im)
    );

    // Output register after the processing element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= vld_q;
            if (vld_q) begin
                out_re <= y_re;
                out_im <= y_im;
            end
        end
    end

    // R7: the two single-port banks are never accessed in the same cycle.
    assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|bsel[0]) && (|bsel[1])));

    // R1: an accepted sample yields a result on the next register stage.
    assert_valid_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> out_valid);

    // R1: without a sample in flight the outputs stay quiet and hold.
    assert_output_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |=> (!out_valid && $stable(out_re) && $stable(out_im)));

endmodule

// File: tb/tb_sdf_mem_stage.sv
// Bench for the delay-feedback stage: two instances (DEPTH 8 and 4) with the
// same stimulus, each compared with a behavioural model on every clock.
module tb_sdf_mem_stage;

    localparam int DW = 12;
    localparam int OW = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;

    logic v8, v4;
    logic signed [OW-1:0] re8, im8, re4, im4;

    always #10 clk = ~clk;

    sdf_mem_stage #(.DEPTH(8), .DATA_W(DW), .TW_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(v8), .out_re(re8), .out_im(im8));

    sdf_mem_stage #(.DEPTH(4), .DATA_W(DW), .TW_W(16)) dut_d4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(v4), .out_re(re4), .out_im(im4));

    typedef struct {
        int re;
        int im;
        int tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int   cnt   [2];
    int   mr    [2][8];
    int   mi    [2][8];
    int   tag_ovr = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [1:0] vhist = 2'b00;
    bit   running = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int twq(input real v);
        real s;
        s = v * 16384.0;
        return (s < 0.0) ? $rtoi(s - 0.5) : $rtoi(s + 0.5);
    endfunction

    task automatic model_clear();
        for (int u = 0; u < 2; u++) begin
            cnt[u] = 0;
            for (int k = 0; k < 8; k++) begin
                mr[u][k] = 0;
                mi[u][k] = 0;
            end
        end
        q0.delete();
        q1.delete();
    endtask

    // Behavioural stage: groups of 2D samples, fill then butterfly (R2, R3, R5).
    task automatic model_push(input int u, input int xr, input int xi);
        int d, p, wr, wi, dr, di;
        longint pr, pi;
        real ang;
        exp_t e;
        d = (u == 0) ? 8 : 4;
        p = cnt[u] % d;
        if (((cnt[u] / d) % 2) == 0) begin
            e.re = mr[u][p];
            e.im = mi[u][p];
            if (cnt[u] < d)
                e.tag = 6;
            else if (e.re > 2047 || e.re < -2048 || e.im > 2047 || e.im < -2048)
                e.tag = 4;
            else
                e.tag = 2;
            mr[u][p] = xr;
            mi[u][p] = xi;
        end else begin
            ang = 6.283185307179586 * real'(p) / real'(2 * d);
            wr = twq($cos(ang));
            wi = twq(-$sin(ang));
            dr = mr[u][p] - xr;
            di = mi[u][p] - xi;
            pr = longint'(dr) * wr - longint'(di) * wi;
            pi = longint'(dr) * wi + longint'(di) * wr;
            e.re = int'(pr >>> 14);
            e.im = int'(pi >>> 14);
            e.tag = (tag_ovr != 0) ? tag_ovr : 3;
            mr[u][p] = mr[u][p] + xr;
            mi[u][p] = mi[u][p] + xi;
        end
        if (u == 0) q0.push_back(e);
        else q1.push_back(e);
        cnt[u]++;
    endtask

    task automatic send(input bit v, input int xr, input int xi);
        @(negedge clk);
        in_valid = v;
        in_re = DW'(xr);
        in_im = DW'(xi);
        if (v) begin
            model_push(0, xr, xi);
            model_push(1, xr, xi);
        end
    endtask

    function automatic int rnd();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    // Expected valid pipeline: two registers from in_valid to out_valid (R1).
    always @(posedge clk) begin
        if (!rst_n) vhist <= 2'b00;
        else vhist <= {vhist[0], in_valid};
    end

    task automatic cmp_unit(input int u, input logic v, input logic signed [OW-1:0] ar,
                            input logic signed [OW-1:0] ai);
        exp_t e;
        chk(v == vhist[1], "R1 valid timing", longint'(v), longint'(vhist[1]));
        if (v) begin
            if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
                chk(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                e = (u == 0) ? q0.pop_front() : q1.pop_front();
                chk(int'(ar) == e.re, $sformatf("R%0d re unit%0d", e.tag, u), longint'(ar), longint'(e.re));
                chk(int'(ai) == e.im, $sformatf("R%0d im unit%0d", e.tag, u), longint'(ai), longint'(e.im));
            end
        end
    endtask

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (running && rst_n) begin
            cmp_unit(0, v8, re8, im8);
            cmp_unit(1, v4, re4, im4);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: reset state at the ports
        chk(v8 == 1'b0 && v4 == 1'b0, "R6 valid in reset", longint'({v8, v4}), 0);
        chk(re8 == 0 && im8 == 0 && re4 == 0 && im4 == 0, "R6 data in reset",
            longint'(re8) + longint'(im8), 0);
        rst_n = 1'b1;
        running = 1'b1;

        // R2 R3: continuous random samples
        for (int i = 0; i < 64; i++) send(1'b1, rnd(), rnd());
        // R1 R7: random idle gaps, position advances only on valid
        for (int i = 0; i < 64; i++) begin
            if ($urandom_range(0, 1) == 1) send(1'b0, 0, 0);
            send(1'b1, rnd(), rnd());
        end
        // R5: constant difference exposes each twiddle directly
        tag_ovr = 5;
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 8; i++) send(1'b1, 1000, 700);
            for (int i = 0; i < 8; i++) send(1'b1, 0, 0);
        end
        tag_ovr = 0;
        // R4: extreme sums must survive the feedback path
        for (int i = 0; i < 16; i++) send(1'b1, -2048, -2048);
        for (int i = 0; i < 16; i++) send(1'b1, 2047, -2048);
        for (int i = 0; i < 32; i++) send(1'b1, 0, 0);
        for (int i = 0; i < 4; i++) send(1'b0, 0, 0);

        // R6: reset mid-run with non-zero storage, first fill outputs are zero
        for (int i = 0; i < 8; i++) send(1'b1, rnd(), rnd());
        for (int i = 0; i < 4; i++) send(1'b0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        chk(v8 == 1'b0 && re8 == 0, "R6 outputs cleared", longint'(re8), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) send(1'b1, rnd(), rnd());
        for (int i = 0; i < 5; i++) send(1'b0, 0, 0);

        // R1: every accepted sample produced exactly one result
        chk(q0.size() == 0, "R1 pending results unit0", longint'(q0.size()), 0);
        chk(q1.size() == 0, "R1 pending results unit1", longint'(q1.size()), 0);
        running = 1'b0;
        summary();
        $finish;
    end

endmodule